// File: doc/BRIEF.md
# ADC Result Sequencer with Instruction-Driven RAM Writes

This block moves ADC conversion results into data RAM under the control of a short program of 8-bit instruction words. Each instruction names which results are wanted from a conversion: the ADC0 result, the ADC1 result, the differential result, or a pair of them. When the ADC side pulses its result strobe, the sequencer captures the selected words. It then issues one 16-bit write per word to a RAM arbiter, at a byte address taken from an internal pointer. The pointer starts at a programmable beginning address and moves forward by the number of bytes stored.

The program sits in a small external instruction memory with a combinational read port, addressed by the sequencer's instruction index. A program ends with one of two special words. The first ends the run and raises a done flag. The second restarts the program from index 0 with the pointer reloaded, which gives continuous acquisition until software stops it. A word outside the legal set stops the run and raises an error flag. A result strobe that arrives while the sequencer is not waiting for one cannot be stored, so it sets a sticky overflow flag.

Top module: `adc_seq_dma`

## Requirements
- R1: After reset, `wr_en`, `busy`, `done`, `overflow`, `bad_instr` and `await_res` are 0. A `start` pulse while idle loads the write pointer from `base_addr` and begins fetching at instruction index 0, presented on `prog_addr`.
- R2: With bit 6 of the instruction clear and bits 3:0 zero, bits 5:4 select the stored words: 01 stores the ADC0 result, 10 stores the ADC1 result, and 11 stores ADC0 first and ADC1 second. Bit 7 has no effect on these words.
- R3: With bit 6 set and bits 3:0 zero, the first stored word is the differential result and bit 4 has no effect. Bit 5 clear stores only that word. Bit 5 set adds the ADC1 result as a second word. Bit 7 has no effect.
- R4: The first word of an instruction is written at the pointer and the second at pointer+2. After the instruction's last write is accepted, the pointer advances by 2 for one word or by 4 for two words.
- R5: Each write carries a whole 16-bit result on `wr_data`, with the high byte in bits 15:8 bound for byte address `wr_addr` and the low byte for `wr_addr`+1. `wr_en`, `wr_addr` and `wr_data` hold steady until `wr_ack` is high at a clock edge.
- R6: For a data instruction the sequencer raises `await_res` and issues no write until `res_valid` is high. All three results are sampled at that strobe edge, and the writes follow from the next cycle.
- R7: Instruction 8'h00 writes nothing, sets `done` and returns to idle (`busy` low).
- R8: Instruction 8'h80 writes nothing, does not set `done`, and restarts the program at index 0 with the pointer reloaded from `base_addr`.
- R9: Any other word is invalid: a nonzero bits 3:0, or bits 6:4 equal to 000 with a value other than 8'h00 or 8'h80. An invalid word writes nothing, sets `bad_instr` and `done`, and returns to idle.
- R10: A `res_valid` pulse while `busy` is high and `await_res` is low sets `overflow`, which stays set until the next start. The results offered with that pulse are discarded, and the pending write keeps its data.
- R11: `stop` high while busy returns the block to idle at the next edge, with no write in progress and `done` left at 0.
- R12: A start clears `done`, `bad_instr` and `overflow`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| stop | input | 1 | Abandon the current run |
| base_addr | input | AW | Beginning byte address for the pointer |
| prog_addr | output | PW | Instruction index toward the instruction memory |
| prog_word | input | 8 | Instruction word at `prog_addr` (combinational read) |
| adc0_res | input | DW | ADC0 conversion result |
| adc1_res | input | DW | ADC1 conversion result |
| diff_res | input | DW | Differential conversion result |
| res_valid | input | 1 | Result strobe, one cycle per conversion |
| await_res | output | 1 | Sequencer is waiting for a result strobe |
| wr_en | output | 1 | Write request toward the RAM arbiter |
| wr_addr | output | AW | Byte address of the high byte of the word |
| wr_data | output | DW | Word to write, high byte in the upper half |
| wr_ack | input | 1 | Arbiter accepts the pending write |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run ended by an end word or an invalid word |
| overflow | output | 1 | A result strobe was lost |
| bad_instr | output | 1 | Run ended on an invalid word |

## Verification
The two functions that can collide are storing a word and accepting a new conversion. A result strobe can arrive in the very cycle that a previous word is still waiting for the arbiter. The bench provokes this by holding `wr_ack` low after a strobe, so the write stays pending, and then pulsing `res_valid` again. It then judges three things: `overflow` rises at the next edge, the pending write keeps its address and its originally captured data, and the run still completes normally once `wr_ack` returns.

// File: rtl/adcseq_pkg.sv
// Package: shared types for the ADC result sequencer.
// Assumes: instruction words are 8 bits; at most two result words per instruction.
package adcseq_pkg;

    // Class of a fetched instruction word
    typedef enum logic [1:0] {
        K_DATA = 2'd0,
        K_END  = 2'd1,
        K_LOOP = 2'd2,
        K_BAD  = 2'd3
    } ikind_t;

    // Source of a stored result word
    typedef enum logic [1:0] {
        SRC_A0 = 2'd0,
        SRC_A1 = 2'd1,
        SRC_DF = 2'd2
    } src_t;

    // Decoded instruction
    typedef struct packed {
        ikind_t kind;
        src_t   first;
        logic   two;
    } idec_t;

    // Sequencer states
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_WAIT  = 3'd2,
        S_WR0   = 3'd3,
        S_WR1   = 3'd4
    } st_t;

endpackage

// File: rtl/adcseq_decode.sv
// Module: instruction decoder.
// Turns one 8-bit instruction word into its class, the source of the first
// stored word, and whether a second (ADC1) word follows.
// Assumes: purely combinational; the caller latches the result if needed.
module adcseq_decode
    import adcseq_pkg::*;
(
    input  logic [7:0] iw,
    output idec_t      dec
);

    // Classify the word; bit 7 only matters for the two control words
    always_comb begin
        dec.kind  = K_BAD;
        dec.first = SRC_A0;
        dec.two   = 1'b0;
        if (iw[6:0] == 7'd0) begin
            dec.kind = iw[7] ? K_LOOP : K_END;
        end else if (iw[3:0] == 4'd0) begin
            if (iw[6]) begin
                dec.kind  = K_DATA;
                dec.first = SRC_DF;
                dec.two   = iw[5];
            end else if (iw[5:4] != 2'b00) begin
                dec.kind  = K_DATA;
                dec.first = iw[4] ? SRC_A0 : SRC_A1;
                dec.two   = iw[5] & iw[4];
            end
        end
    end

endmodule

// File: rtl/adcseq_capture.sv
// Module: result capture slots.
// On a take pulse, stores the word for each slot: slot 0 from the selected
// source, slot 1 always from ADC1.
// Assumes: take is high for one cycle per accepted strobe; slots hold otherwise.
module adcseq_capture
    import adcseq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  src_t          first,
    input  logic [DW-1:0] a0,
    input  logic [DW-1:0] a1,
    input  logic [DW-1:0] df,
    output logic [DW-1:0] w0,
    output logic [DW-1:0] w1
);

    localparam int NSLOT = 2;

    logic [DW-1:0] slot [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        src_t          sel;
        logic [DW-1:0] pick;

        // Slot source: slot 0 follows the instruction, later slots take ADC1
        always_comb begin
            sel = (g == 0) ? first : SRC_A1;
            case (sel)
                SRC_A0:  pick = a0;
                SRC_A1:  pick = a1;
                default: pick = df;
            endcase
        end

        // Slot register: load on take, hold otherwise
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (take) begin
                slot[g] <= pick;
            end
        end
    end

    assign w0 = slot[0];
    assign w1 = slot[1];

endmodule

// File: rtl/adcseq_addr.sv
// Module: write address pointer.
// Loads the beginning address, then advances by 2 or 4 bytes per instruction.
// Assumes: load has priority over adv; the address wraps at 2**AW.
module adcseq_addr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          adv,
    input  logic          two,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] STEP1 = AW'(2);
    localparam logic [AW-1:0] STEP2 = AW'(4);

    // Pointer register: reload or advance by the bytes just stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= base;
        end else if (adv) begin
            ptr <= ptr + (two ? STEP2 : STEP1);
        end
    end

endmodule

// File: rtl/adc_seq_dma.sv
// Module: ADC result sequencer (top).
// Fetches instruction words by index, waits for a result strobe, writes one
// or two 16-bit words to the RAM arbiter, and handles end, restart and invalid
// words. Keeps sticky done, error and overflow flags until the next start.
// Assumes: prog_word is the combinational read of prog_addr; wr_ack may stall.
module adc_seq_dma
    import adcseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic [AW-1:0] base_addr,
    output logic [PW-1:0] prog_addr,
    input  logic [7:0]    prog_word,
    input  logic [DW-1:0] adc0_res,
    input  logic [DW-1:0] adc1_res,
    input  logic [DW-1:0] diff_res,
    input  logic          res_valid,
    output logic          await_res,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    input  logic          wr_ack,
    output logic          busy,
    output logic          done,
    output logic          overflow,
    output logic          bad_instr
);

    localparam logic [AW-1:0] WORD_BYTES = AW'(2);
    localparam logic [PW-1:0] IDX_ONE    = PW'(1);

    st_t           st;
    logic [PW-1:0] idx;
    idec_t         dec_now;
    idec_t         cur;
    logic [AW-1:0] ptr;
    logic [DW-1:0] w0;
    logic [DW-1:0] w1;
    logic          take;
    logic          last_wr;
    logic          ptr_load;
    logic          ptr_adv;

    adcseq_decode u_dec (
        .iw  (prog_word),
        .dec (dec_now)
    );

    // Control strobes shared by the pointer and capture units
    always_comb begin
        take     = (st == S_WAIT) && res_valid && !stop;
        last_wr  = wr_ack && (((st == S_WR0) && !cur.two) || (st == S_WR1));
        ptr_adv  = last_wr && !stop;
        ptr_load = ((st == S_IDLE) && start) ||
                   ((st == S_FETCH) && !stop && (dec_now.kind == K_LOOP));
    end

    adcseq_addr #(.AW(AW)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ptr_load),
        .base  (base_addr),
        .adv   (ptr_adv),
        .two   (cur.two),
        .ptr   (ptr)
    );

    adcseq_capture #(.DW(DW)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .first (cur.first),
        .a0    (adc0_res),
        .a1    (adc1_res),
        .df    (diff_res),
        .w0    (w0),
        .w1    (w1)
    );

    // Sequencer state, instruction index and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            idx       <= '0;
            cur       <= '0;
            done      <= 1'b0;
            bad_instr <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            if ((st == S_IDLE) && start) begin
                overflow <= 1'b0;
            end else if ((st != S_IDLE) && (st != S_WAIT) && res_valid) begin
                overflow <= 1'b1;
            end

            if (stop && (st != S_IDLE)) begin
                st <= S_IDLE;
            end else begin
                case (st)
                    S_IDLE: begin
                        if (start) begin
                            st        <= S_FETCH;
                            idx       <= '0;
                            done      <= 1'b0;
                            bad_instr <= 1'b0;
                        end
                    end
                    S_FETCH: begin
                        cur <= dec_now;
                        case (dec_now.kind)
                            K_DATA: st  <= S_WAIT;
                            K_LOOP: idx <= '0;
                            K_END: begin
                                done <= 1'b1;
                                st   <= S_IDLE;
                            end
                            default: begin
                                done      <= 1'b1;
                                bad_instr <= 1'b1;
                                st        <= S_IDLE;
                            end
                        endcase
                    end
                    S_WAIT: begin
                        if (res_valid) begin
                            st <= S_WR0;
                        end
                    end
                    S_WR0: begin
                        if (wr_ack) begin
                            if (cur.two) begin
                                st <= S_WR1;
                            end else begin
                                st  <= S_FETCH;
                                idx <= idx + IDX_ONE;
                            end
                        end
                    end
                    S_WR1: begin
                        if (wr_ack) begin
                            st  <= S_FETCH;
                            idx <= idx + IDX_ONE;
                        end
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    // Write request and status outputs
    always_comb begin
        prog_addr = idx;
        busy      = (st != S_IDLE);
        await_res = (st == S_WAIT);
        wr_en     = (st == S_WR0) || (st == S_WR1);
        wr_addr   = (st == S_WR1) ? (ptr + WORD_BYTES) : ptr;
        wr_data   = (st == S_WR1) ? w1 : w0;
    end

endmodule

// File: rtl/adcseq_chk.sv
// Module: protocol checker for the ADC result sequencer, bound to the top.
// Assumes: observes ports only; all properties are disabled during reset.
module adcseq_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stop,
    input logic          res_valid,
    input logic          await_res,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          wr_ack,
    input logic          busy,
    input logic          done,
    input logic          overflow
);

    // A stalled write keeps its address and data (R5)
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ack && !stop) |=> (wr_en && $stable(wr_addr) && $stable(wr_data)));

    // Back-to-back writes are the two words of one instruction (R4)
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en && wr_ack)) |-> (wr_addr == $past(wr_addr) + AW'(2)));

    // While waiting for a result nothing is written (R6)
    p_wait_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        await_res |-> (!wr_en && busy));

    // A finished run is idle (R7)
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // A strobe arriving when not waiting raises the overflow flag (R10)
    p_ovf_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !await_res && res_valid) |=> overflow);

    // Stop ends the run at the next edge (R11)
    p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && busy) |=> (!busy && !wr_en));

endmodule

bind adc_seq_dma adcseq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop      (stop),
    .res_valid (res_valid),
    .await_res (await_res),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_ack    (wr_ack),
    .busy      (busy),
    .done      (done),
    .overflow  (overflow)
);

// File: tb/adc_seq_dma_bench.sv
// Bench: sweeps every instruction word, then covers restart, stall/overflow,
// stop and flag clearing. Expected writes come from an arithmetic model.
module adc_seq_dma_bench;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int PW = 4;
    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          stop = 1'b0;
    logic          res_valid = 1'b0;
    logic          wr_ack = 1'b1;
    logic [AW-1:0] base_addr = '0;
    logic [PW-1:0] prog_addr;
    logic [7:0]    prog_word;
    logic [DW-1:0] adc0_res, adc1_res, diff_res;
    logic          await_res, wr_en, busy, done, overflow, bad_instr;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    logic [7:0]    prog [NP];
    int            n_chk = 0;
    int            n_bad = 0;
    int            ns = 0;

    logic [AW-1:0] got_a [32];
    logic [DW-1:0] got_d [32];
    int            ngot;
    logic [AW-1:0] exp_a [32];
    logic [DW-1:0] exp_d [32];
    int            nexp;
    bit            exp_badf;

    always #2 clk = ~clk;

    function automatic logic [15:0] v0(int k);
        return 16'(32'hA105 + k * 32'h0107);
    endfunction
    function automatic logic [15:0] v1(int k);
        return 16'(32'h52C3 + k * 32'h0213);
    endfunction
    function automatic logic [15:0] vd(int k);
        return 16'(32'hC37A ^ (k * 32'h0311));
    endfunction

    assign prog_word = prog[prog_addr];
    assign adc0_res  = v0(ns);
    assign adc1_res  = v1(ns);
    assign diff_res  = vd(ns);

    adc_seq_dma #(.AW(AW), .DW(DW), .PW(PW)) u_adc_seq_dma (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .base_addr(base_addr), .prog_addr(prog_addr), .prog_word(prog_word),
        .adc0_res(adc0_res), .adc1_res(adc1_res), .diff_res(diff_res),
        .res_valid(res_valid), .await_res(await_res), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack), .busy(busy),
        .done(done), .overflow(overflow), .bad_instr(bad_instr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Model of one run over prog[] from the requirements
    task automatic build_exp(input logic [AW-1:0] base);
        logic [AW-1:0] p;
        logic [7:0]    w;
        int            k;
        p = base; k = 0; nexp = 0; exp_badf = 0;
        for (int i = 0; i < NP; i++) begin
            w = prog[i];
            if (w == 8'h00 || w == 8'h80) break;
            if (w[3:0] != 4'd0 || w[6:4] == 3'b000) begin
                exp_badf = 1;
                break;
            end
            exp_a[nexp] = p;
            exp_d[nexp] = w[6] ? vd(k) : (w[4] ? v0(k) : v1(k));
            nexp++;
            if (w[5] && (w[6] || w[4])) begin
                exp_a[nexp] = p + AW'(2);
                exp_d[nexp] = v1(k);
                nexp++;
                p = p + AW'(4);
            end else begin
                p = p + AW'(2);
            end
            k++;
        end
    endtask

    // Run the program, answering await_res with strobes; stop after maxw writes
    task automatic run_prog(input int maxw);
        ns = 0; ngot = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int g = 0; g < 400; g++) begin
            if (res_valid) begin
                res_valid = 1'b0;
                ns++;
            end
            if (stop) stop = 1'b0;
            if (!busy) break;
            if (wr_en && wr_ack && ngot < 32) begin
                got_a[ngot] = wr_addr;
                got_d[ngot] = wr_data;
                ngot++;
            end
            if (ngot >= maxw) stop = 1'b1;
            else if (await_res) res_valid = 1'b1;
            @(negedge clk);
        end
        stop = 1'b0;
        res_valid = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_bad++;
        $display("FAIL R6 watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) prog[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!wr_en && !busy && !done && !overflow && !bad_instr && !await_res, "R1 reset",
            {26'd0, wr_en, busy, done, overflow, bad_instr, await_res}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep every word as instruction 0, followed by a two-word instruction
        for (int w = 0; w < 256; w++) begin
            if (w == 8'h80) continue;
            prog[0] = 8'(w);
            prog[1] = 8'h30;
            prog[2] = 8'h00;
            base_addr = AW'(16'h2006 + w * 16);
            build_exp(base_addr);
            run_prog(1000);
            chk(ngot == nexp, "R4 write count", 32'(ngot), 32'(nexp));
            for (int j = 0; j < nexp && j < ngot; j++) begin
                chk(got_a[j] == exp_a[j], "R4 address", 32'(got_a[j]), 32'(exp_a[j]));
                chk(got_d[j] == exp_d[j], w[6] ? "R3 R5 data" : "R2 R5 data",
                    32'(got_d[j]), 32'(exp_d[j]));
            end
            if (nexp > 0)
                chk(got_a[0] == base_addr, "R1 first address", 32'(got_a[0]), 32'(base_addr));
            chk(bad_instr == exp_badf, "R9 bad flag", 32'(bad_instr), 32'(exp_badf));
            chk(done && !busy, "R7 done", {30'd0, done, busy}, 32'h2);
            chk(!overflow, "R10 no overflow", 32'(overflow), 32'd0);
        end

        // R8: restart word reloads pointer and index
        prog[0] = 8'h30; prog[1] = 8'h20; prog[2] = 8'h80; prog[3] = 8'h00;
        base_addr = 16'h0400;
        run_prog(6);
        chk(ngot == 6, "R8 write count", 32'(ngot), 32'd6);
        for (int j = 0; j < 6 && j < ngot; j++) begin
            int            lap;
            int            pos;
            logic [DW-1:0] ed;
            lap = j / 3; pos = j % 3;
            ed = (pos == 0) ? v0(lap * 2) : (pos == 1) ? v1(lap * 2) : v1(lap * 2 + 1);
            chk(got_a[j] == AW'(16'h0400 + pos * 2), "R8 address", 32'(got_a[j]), 32'(16'h0400 + pos * 2));
            chk(got_d[j] == ed, "R8 data", 32'(got_d[j]), 32'(ed));
        end
        chk(!done && !busy, "R11 stopped loop", {30'd0, done, busy}, 32'd0);

        // R6, R5, R10: wait for strobe, stall the write, collide a second strobe
        prog[0] = 8'h10; prog[1] = 8'h00;
        base_addr = 16'h0100;
        wr_ack = 1'b0; ns = 5;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (8) @(negedge clk);
        chk(await_res && !wr_en, "R6 waits", {30'd0, await_res, wr_en}, 32'h2);
        res_valid = 1'b1;
        @(negedge clk) res_valid = 1'b0;
        chk(wr_en && wr_addr == 16'h0100, "R5 write addr", 32'(wr_addr), 32'h0100);
        chk(wr_data == v0(5), "R6 sampled data", 32'(wr_data), 32'(v0(5)));
        ns = 6;
        repeat (3) begin
            @(negedge clk);
            chk(wr_en && wr_data == v0(5) && wr_addr == 16'h0100, "R5 hold", 32'(wr_data), 32'(v0(5)));
        end
        res_valid = 1'b1;
        @(negedge clk) res_valid = 1'b0;
        chk(overflow, "R10 overflow set", 32'(overflow), 32'd1);
        chk(wr_data == v0(5), "R10 data kept", 32'(wr_data), 32'(v0(5)));
        wr_ack = 1'b1;
        repeat (2) @(negedge clk);
        chk(done && !busy && overflow, "R10 sticky", {29'd0, done, busy, overflow}, 32'h5);

        // R12: new start clears overflow
        prog[0] = 8'h00;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        @(negedge clk);
        chk(!overflow && done && !bad_instr, "R12 clear ovf", {29'd0, overflow, done, bad_instr}, 32'h2);

        // R12: bad flag cleared by next run
        prog[0] = 8'h01;
        run_prog(1000);
        chk(bad_instr, "R9 bad word", 32'(bad_instr), 32'd1);
        prog[0] = 8'h00;
        run_prog(1000);
        chk(!bad_instr, "R12 clear bad", 32'(bad_instr), 32'd0);

        // R11: stop while waiting, then stop during a stalled write
        prog[0] = 8'h10; prog[1] = 8'h00;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (3) @(negedge clk);
        stop = 1'b1;
        @(negedge clk) stop = 1'b0;
        chk(!busy && !done && !await_res, "R11 stop wait", {29'd0, busy, done, await_res}, 32'd0);
        wr_ack = 1'b0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (2) @(negedge clk);
        res_valid = 1'b1;
        @(negedge clk) res_valid = 1'b0;
        stop = 1'b1;
        @(negedge clk) stop = 1'b0;
        chk(!busy && !wr_en && !done, "R11 stop write", {29'd0, busy, wr_en, done}, 32'd0);
        wr_ack = 1'b1;

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule